// File: doc/BRIEF.md
# One-Wire Feature Configuration and Strong-Pullup Control

This block keeps the four feature switches that a host sets for a one-wire bus master: active pullup, presence-pulse masking, strong pullup and overdrive speed. The host writes a byte through a simple write strobe, and the block reads it back at all times. A write is guarded. It takes effect only when its high nibble is the bitwise inverse of its low nibble, so a corrupted or careless write leaves the register as it was.

The block also runs the strong-pullup episode. When the host sets the strong-pullup bit and then issues a write-byte or single-bit bus command, the block arms. When the bus engine reports that the command's final slot is complete, the block turns on the internal pullup and drives the active-low external pullup control low. The episode ends on a new bus command, on a configuration write that clears the strong-pullup bit, or on a device reset. When it ends, the strong-pullup bit clears itself and the other three bits keep their values.

Top module: `spu_cfg_top`

## Requirements
- R1: After power-up reset (rstN low), cfgRdData reads 8'h00, all four feature outputs are 0, pullupEn is 0 and extPullupN is 1.
- R2: A write with cfgWrData[7:4] == ~cfgWrData[3:0] is accepted. From the next cycle, cfgRdData[3:0] holds cfgWrData[3:0] and cfgRdData[7:4] reads 0.
- R3: A write whose high nibble is not the inverse of its low nibble leaves cfgRdData and the pullup outputs unchanged, including while a strong-pullup episode is running.
- R4: A devReset pulse makes cfgRdData 8'h00 from the next cycle. It drops pullupEn in its own cycle, and the episode stays ended afterwards.
- R5: The feature outputs follow the stored bits: bit0 drives apuEn, bit1 drives ppmEn, bit2 drives spuBit and bit3 drives odSpeed.
- R6: If a bus command with busCmdQual=1 (write-byte or single-bit) is accepted while bit2 is set, pullupEn rises and extPullupN falls in the cycle after the next slotDone pulse. Both hold until an ending event.
- R7: Setting bit2 only arms the episode. Nothing is driven for a command with busCmdQual=0, for a qualifying command issued while bit2 is 0, before slotDone, or when bit2 is cleared between the command and slotDone.
- R8: A busCmdValid pulse during an episode drops pullupEn in the same cycle. From the next cycle, bit2 reads 0, bits 0, 1 and 3 are unchanged, and a later slotDone does not restart the pullup.
- R9: An accepted write with bit2 = 0 during an episode ends the pullup from the next cycle. The register then holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| cfgWrEn | input | 1 | Host configuration write strobe, one cycle |
| cfgWrData | input | 8 | Host write byte: guard nibble in the high half, features in the low half |
| cfgRdData | output | 8 | Read-back byte: features in the low nibble, zero in the high nibble |
| devReset | input | 1 | Device-reset command pulse |
| busCmdValid | input | 1 | A bus-activity command is accepted this cycle |
| busCmdQual | input | 1 | With busCmdValid: 1 = write-byte or single-bit command |
| slotDone | input | 1 | The bus engine finished the last slot of the current command |
| apuEn | output | 1 | Active pullup enable (bit0) |
| ppmEn | output | 1 | Presence-pulse masking enable (bit1) |
| spuBit | output | 1 | Strong-pullup request bit (bit2) |
| odSpeed | output | 1 | Overdrive speed select (bit3) |
| pullupEn | output | 1 | Internal strong-pullup transistor enable |
| extPullupN | output | 1 | Active-low external pullup control |

## Verification
Register contents and the start of the pullup are registered, so they are due one cycle after the edge that sees the write, devReset or slotDone strobe. The bench drives each strobe for exactly one edge and samples on the following falling edge. The drop of pullupEn on a bus command or devReset is combinational, so the bench checks it half a cycle after raising the strobe, before the edge that captures it. The bench then checks the cleared bit2 on the next falling edge. Each sample is queued with its expected value and compared by a monitor at that point, so no sample depends on the order of processes at a clock edge.

// File: rtl/spu_cfg_pkg.sv
`timescale 1ns/1ps
package spu_cfg_pkg;
  localparam int CFG_W   = 8;
  localparam int FEAT_W  = 4;
  localparam int BIT_APU = 0;
  localparam int BIT_PPM = 1;
  localparam int BIT_SPU = 2;
  localparam int BIT_OD  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // device reset: wipe every feature bit
    logic load;     // accepted host write
    logic clrSpu;   // episode ended by bus activity: drop bit2
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_guard.sv
`timescale 1ns/1ps
module cfg_guard #(
  parameter int W = 8
) (
  input  logic [W-1:0] wrData,
  output logic         guardOk
);
  localparam int H = W / 2;

  logic [H-1:0] pairOk;

  for (genvar i = 0; i < H; i++) begin : g_pair
    assign pairOk[i] = wrData[i] ^ wrData[i+H];
  end

  assign guardOk = &pairOk;
endmodule

// File: rtl/cfg_datapath.sv
`timescale 1ns/1ps
module cfg_datapath
  import spu_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic              wrEn,
  input  logic              guardOk,
  input  logic [FEAT_W-1:0] wrLow,
  output logic [FEAT_W-1:0] cfgBits,
  output logic [CFG_W-1:0]  rdData
);
  logic [FEAT_W-1:0] cfgQ, cfgD;

  always_comb begin
    cfgD = strobe.load ? wrLow : cfgQ;
    if (strobe.clrSpu) cfgD[BIT_SPU] = 1'b0;
    if (strobe.clrAll) cfgD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgD;
  end

  assign cfgBits = cfgQ;
  assign rdData  = {{(CFG_W-FEAT_W){1'b0}}, cfgQ};

  // R3
  bad_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !guardOk && !strobe.clrAll && !strobe.clrSpu) |=> $stable(cfgQ));

  // R2
  good_write_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.clrAll && !strobe.clrSpu) |=> (cfgQ == $past(wrLow)));
endmodule

// File: rtl/spu_ctrl.sv
`timescale 1ns/1ps
module spu_ctrl
  import spu_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              guardOk,
  input  logic              wrSpu,
  input  logic              devReset,
  input  logic              busCmdValid,
  input  logic              busCmdQual,
  input  logic              slotDone,
  input  logic [FEAT_W-1:0] cfgBits,
  output cfgStrobe_t        strobe,
  output logic              pullupEn
);
  logic armedQ, armedD;
  logic spuOnQ, spuOnD;
  logic wrAccept, wrClearsSpu, spuReq, endEvt;

  assign wrAccept    = wrEn & guardOk;
  assign wrClearsSpu = wrAccept & ~wrSpu;
  assign spuReq      = cfgBits[BIT_SPU];
  assign endEvt      = spuOnQ & (busCmdValid | wrClearsSpu);

  always_comb begin
    if (devReset)         armedD = 1'b0;
    else if (busCmdValid) armedD = busCmdQual & spuReq & ~spuOnQ & ~wrClearsSpu;
    else if (slotDone)    armedD = 1'b0;
    else                  armedD = armedQ;
  end

  always_comb begin
    if (devReset)    spuOnD = 1'b0;
    else if (spuOnQ) spuOnD = ~endEvt;
    else             spuOnD = slotDone & armedQ & spuReq & ~busCmdValid & ~wrClearsSpu;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      spuOnQ <= 1'b0;
    end else begin
      armedQ <= armedD;
      spuOnQ <= spuOnD;
    end
  end

  always_comb begin
    strobe.clrAll = devReset;
    strobe.load   = wrAccept;
    strobe.clrSpu = spuOnQ & busCmdValid;
  end

  // drop at once when bus activity or reset is accepted
  assign pullupEn = spuOnQ & ~busCmdValid & ~devReset;

  // R6
  spu_needs_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    spuOnQ |-> spuReq);

  // R6
  spu_rise_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spuOnQ) |-> $past(slotDone));

  // R8
  cmd_ends_spu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spuOnQ && busCmdValid) |=> (!spuOnQ && !spuReq));

  // R4
  dev_reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    devReset |=> (cfgBits == '0 && !spuOnQ));
endmodule

// File: rtl/spu_cfg_top.sv
`timescale 1ns/1ps
module spu_cfg_top
  import spu_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             devReset,
  input  logic             busCmdValid,
  input  logic             busCmdQual,
  input  logic             slotDone,
  output logic             apuEn,
  output logic             ppmEn,
  output logic             spuBit,
  output logic             odSpeed,
  output logic             pullupEn,
  output logic             extPullupN
);
  cfgStrobe_t        strobe;
  logic              guardOk;
  logic [FEAT_W-1:0] cfgBits;

  cfg_guard #(.W(CFG_W)) guard_i (
    .wrData (cfgWrData),
    .guardOk(guardOk)
  );

  spu_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (cfgWrEn),
    .guardOk    (guardOk),
    .wrSpu      (cfgWrData[BIT_SPU]),
    .devReset   (devReset),
    .busCmdValid(busCmdValid),
    .busCmdQual (busCmdQual),
    .slotDone   (slotDone),
    .cfgBits    (cfgBits),
    .strobe     (strobe),
    .pullupEn   (pullupEn)
  );

  cfg_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrEn   (cfgWrEn),
    .guardOk(guardOk),
    .wrLow  (cfgWrData[FEAT_W-1:0]),
    .cfgBits(cfgBits),
    .rdData (cfgRdData)
  );

  assign apuEn      = cfgBits[BIT_APU];
  assign ppmEn      = cfgBits[BIT_PPM];
  assign spuBit     = cfgBits[BIT_SPU];
  assign odSpeed    = cfgBits[BIT_OD];
  assign extPullupN = ~pullupEn;
endmodule

// File: tb/spu_cfg_top_tb_top.sv
`timescale 1ns/1ps
module spu_cfg_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       devReset = 1'b0;
  logic       busCmdValid = 1'b0;
  logic       busCmdQual = 1'b0;
  logic       slotDone = 1'b0;
  logic       apuEn, ppmEn, spuBit, odSpeed, pullupEn, extPullupN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       pu;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;

  always #5 clk = ~clk;

  spu_cfg_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .devReset(devReset), .busCmdValid(busCmdValid),
    .busCmdQual(busCmdQual), .slotDone(slotDone), .apuEn(apuEn), .ppmEn(ppmEn),
    .spuBit(spuBit), .odSpeed(odSpeed), .pullupEn(pullupEn), .extPullupN(extPullupN)
  );

  // monitor: pops each expectation and compares at the sampling point
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [3:0] feat;
        it = expQ.pop_front();
        feat = {odSpeed, spuBit, ppmEn, apuEn};
        checks++;
        if (cfgRdData !== it.rd || pullupEn !== it.pu || extPullupN !== ~it.pu ||
            feat !== it.rd[3:0]) begin
          fails++;
          $display("FAIL %s: rd=%02h pu=%b extN=%b feat=%b expected rd=%02h pu=%b extN=%b feat=%b",
                   it.tag, cfgRdData, pullupEn, extPullupN, feat,
                   it.rd, it.pu, ~it.pu, it.rd[3:0]);
        end
      end
    end
  end

  task automatic expect_now(input string tag, input logic [7:0] rd, input logic pu);
    expItem_t it;
    it.tag = tag; it.rd = rd; it.pu = pu;
    expQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0; busCmdValid = 1'b0; busCmdQual = 1'b0;
    slotDone = 1'b0; devReset = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] d);
    cfgWrEn = 1'b1; cfgWrData = d; tick();
  endtask

  task automatic doCmd(input logic q);
    busCmdValid = 1'b1; busCmdQual = q; tick();
  endtask

  task automatic doSlot();
    slotDone = 1'b1; tick();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    expect_now("R1 reset state", 8'h00, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    expect_now("R1 after release", 8'h00, 1'b0);

    doWrite(8'hE1); expect_now("R2 R5 apu only", 8'h01, 1'b0);
    doWrite(8'h5A); expect_now("R5 ppm and od", 8'h0A, 1'b0);
    doWrite(8'h33); expect_now("R3 bad guard 33", 8'h0A, 1'b0);
    doWrite(8'hFF); expect_now("R3 bad guard FF", 8'h0A, 1'b0);
    doWrite(8'h0F); expect_now("R2 all ones", 8'h0F, 1'b0);
    doWrite(8'hF0); expect_now("R2 all zeros", 8'h00, 1'b0);

    doWrite(8'hB4); expect_now("R7 spu armed only", 8'h04, 1'b0);
    doCmd(1'b0);    expect_now("R7 nonqual cmd", 8'h04, 1'b0);
    doSlot();       expect_now("R7 nonqual slot", 8'h04, 1'b0);

    doWrite(8'h0F);
    doCmd(1'b1);    expect_now("R7 qual cmd before slot", 8'h0F, 1'b0);
    tick();         expect_now("R7 waiting for slot", 8'h0F, 1'b0);
    doSlot();       expect_now("R6 pullup on", 8'h0F, 1'b1);
    tick();         expect_now("R6 pullup held", 8'h0F, 1'b1);
    doWrite(8'h77); expect_now("R3 bad guard during episode", 8'h0F, 1'b1);

    busCmdValid = 1'b1; busCmdQual = 1'b1; #1;
    expect_now("R8 same-cycle drop", 8'h0F, 1'b0);
    tick();         expect_now("R8 spu cleared others kept", 8'h0B, 1'b0);
    doSlot();       expect_now("R8 no restart", 8'h0B, 1'b0);

    doWrite(8'h0F); doCmd(1'b1); doSlot();
    expect_now("R6 second episode", 8'h0F, 1'b1);
    doWrite(8'h4B); expect_now("R9 write clears spu", 8'h0B, 1'b0);
    doSlot();       expect_now("R9 stays off", 8'h0B, 1'b0);

    doWrite(8'h0F); doCmd(1'b1); doSlot();
    expect_now("R6 third episode", 8'h0F, 1'b1);
    devReset = 1'b1; #1;
    expect_now("R4 same-cycle drop", 8'h0F, 1'b0);
    tick();         expect_now("R4 cleared", 8'h00, 1'b0);
    tick();         expect_now("R4 stays ended", 8'h00, 1'b0);

    doWrite(8'hB4); doCmd(1'b1);
    doWrite(8'hF0); doSlot();
    expect_now("R7 bit cleared before slot", 8'h00, 1'b0);

    doWrite(8'hE1); doCmd(1'b1);
    doWrite(8'hB4); doSlot();
    expect_now("R7 qual cmd issued with spu 0", 8'h04, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule